// File: doc/BRIEF.md
# Partitioned Vector Bit-Flip Unit

This execution unit sits on a 128-bit vector datapath. It decodes one 32-bit three-register instruction word and, when the word names the bit-negate operation, treats the first source vector as a set of equal-sized lanes. In every lane it complements one bit. A 2-bit format field in the instruction sets the lane width at run time to 8, 16, 32 or 64 bits. Each lane takes its bit position from the low bits of the matching lane of the second source vector, so the position wraps modulo the lane width.

The result, the destination register index, a one-cycle valid strobe and two exception flags are registered on the clock edge after the word is issued. The two exceptions are an illegal encoding and a switched-off vector unit. The operation can never raise an exception that depends on the data. Register file access, writeback and hazard handling belong to the surrounding pipeline.

Top module: `vbitflip_unit`

## Requirements
- R1: Instruction fields run, from bit 31 down, as major[31:26], op[25:23], fmt[22:21], wt[20:16], ws[15:11], wd[10:6] and minor[5:0]. The operation matches when major=011110, op=101 and minor=001101. A matching word issued with `vec_en` high raises `res_vld` for exactly the next cycle.
- R2: With fmt=00 (8-bit lanes), each byte lane of `res_q` equals the `src_a` lane XOR a one-hot mask at position `src_b` lane bits [2:0].
- R3: With fmt=01 (16-bit lanes), the position is `src_b` lane bits [3:0].
- R4: With fmt=10 (32-bit lanes), the position is `src_b` lane bits [4:0].
- R5: With fmt=11 (64-bit lanes), the position is `src_b` lane bits [5:0].
- R6: Bits of each `src_b` lane above the index bits have no effect on `res_q`.
- R7: When `res_vld` is high, `dst_q` equals the wd field, bits [10:6] of the issued word.
- R8: A word with major=011110 issued while `vec_en` is low raises `exc_off` for one cycle. In that cycle `res_vld` and `exc_rsvd` stay low, whatever the other fields hold.
- R9: A word with major=011110 whose op or minor field differs from the match, issued while `vec_en` is high, raises `exc_rsvd` for one cycle, and `res_vld` stays low.
- R10: A word with any other major opcode, or a cycle with `issue` low, leaves `res_vld`, `exc_rsvd` and `exc_off` low in the next cycle.
- R11: While `rst_n` is low, `res_q`, `dst_q`, `res_vld`, `exc_rsvd` and `exc_off` are all zero.
- R12: At most one of `res_vld`, `exc_rsvd` and `exc_off` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Instruction word is presented this cycle |
| insn | input | 32 | Instruction word |
| vec_en | input | 1 | Vector unit enabled |
| src_a | input | VW | Vector whose bits are flipped (ws) |
| src_b | input | VW | Vector of per-lane bit positions (wt) |
| res_q | output | VW | Registered result vector |
| dst_q | output | 5 | Registered destination register index |
| res_vld | output | 1 | Result valid strobe |
| exc_rsvd | output | 1 | Reserved-encoding exception |
| exc_off | output | 1 | Vector-unit-disabled exception |

## Verification
On every cycle the assertions check that the three strobes are exclusive and that decoding under each enable state is correct. They also check that a valid result differs from its source in exactly one bit per lane, and that the destination index follows the wd field. The bench scenarios are what show that the flipped bit sits at the right position in each format, that the upper bits of the index lane are ignored, and that lanes wrap correctly at each width.

// File: rtl/vbitflip_unit.sv
module vbitflip_unit #(
  parameter int VW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic [31:0]   insn,
  input  logic          vec_en,
  input  logic [VW-1:0] src_a,
  input  logic [VW-1:0] src_b,
  output logic [VW-1:0] res_q,
  output logic [4:0]    dst_q,
  output logic          res_vld,
  output logic          exc_rsvd,
  output logic          exc_off
);
  localparam logic [5:0] MAJOR = 6'b011110;
  localparam logic [2:0] OPSEL = 3'b101;
  localparam logic [5:0] MINOR = 6'b001101;

  wire hit_major = issue && (insn[31:26] == MAJOR);
  wire hit_op    = (insn[25:23] == OPSEL) && (insn[5:0] == MINOR);
  wire do_flip   = hit_major && vec_en && hit_op;

  logic [VW-1:0] flip8, flip16, flip32, flip64, nxt;

  for (genvar i = 0; i < VW/8; i++) begin : g_b
    assign flip8[8*i +: 8] = src_a[8*i +: 8] ^ (8'd1 << src_b[8*i +: 3]);
  end
  for (genvar i = 0; i < VW/16; i++) begin : g_h
    assign flip16[16*i +: 16] = src_a[16*i +: 16] ^ (16'd1 << src_b[16*i +: 4]);
  end
  for (genvar i = 0; i < VW/32; i++) begin : g_w
    assign flip32[32*i +: 32] = src_a[32*i +: 32] ^ (32'd1 << src_b[32*i +: 5]);
  end
  for (genvar i = 0; i < VW/64; i++) begin : g_d
    assign flip64[64*i +: 64] = src_a[64*i +: 64] ^ (64'd1 << src_b[64*i +: 6]);
  end

  always_comb begin
    case (insn[22:21])
      2'b00:   nxt = flip8;
      2'b01:   nxt = flip16;
      2'b10:   nxt = flip32;
      default: nxt = flip64;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q    <= '0;
      dst_q    <= '0;
      res_vld  <= 1'b0;
      exc_rsvd <= 1'b0;
      exc_off  <= 1'b0;
    end else begin
      res_vld  <= do_flip;
      exc_off  <= hit_major && !vec_en;
      exc_rsvd <= hit_major && vec_en && !hit_op;
      if (do_flip) begin
        res_q <= nxt;
        dst_q <= insn[10:6];
      end
    end
  end
endmodule

// File: rtl/vbitflip_chk.sv
module vbitflip_chk #(
  parameter int VW = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          issue,
  input logic [31:0]   insn,
  input logic          vec_en,
  input logic [VW-1:0] src_a,
  input logic [VW-1:0] res_q,
  input logic [4:0]    dst_q,
  input logic          res_vld,
  input logic          exc_rsvd,
  input logic          exc_off
);
  p_one_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({res_vld, exc_rsvd, exc_off}));

  p_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && insn[31:26] == 6'b011110 && !vec_en) |=> (exc_off && !res_vld && !exc_rsvd));

  p_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && insn[31:26] == 6'b011110 && vec_en &&
     (insn[25:23] != 3'b101 || insn[5:0] != 6'b001101)) |=> (exc_rsvd && !res_vld));

  p_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!issue || insn[31:26] != 6'b011110) |=> (!res_vld && !exc_rsvd && !exc_off));

  p_issue_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && insn[31:26] == 6'b011110 && vec_en && insn[25:23] == 3'b101 &&
     insn[5:0] == 6'b001101) |=> res_vld);

  p_lane_flips_r2: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> ($countones(res_q ^ $past(src_a)) == (VW >> (3 + int'($past(insn[22:21]))))));

  p_dest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> (dst_q == $past(insn[10:6])));
endmodule

bind vbitflip_unit vbitflip_chk #(.VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .issue(issue), .insn(insn), .vec_en(vec_en),
  .src_a(src_a), .res_q(res_q), .dst_q(dst_q), .res_vld(res_vld),
  .exc_rsvd(exc_rsvd), .exc_off(exc_off)
);

// File: tb/tb_vbitflip_unit.sv
`timescale 1ns/1ps
module tb_vbitflip_unit;
  localparam int VW = 128;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic issue = 1'b0;
  logic [31:0] insn = '0;
  logic vec_en = 1'b0;
  logic [VW-1:0] src_a = '0, src_b = '0;
  logic [VW-1:0] res_q;
  logic [4:0] dst_q;
  logic res_vld, exc_rsvd, exc_off;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  vbitflip_unit #(.VW(VW)) dut (.*);

  localparam int NV = 8;
  localparam logic [1:0] T_FMT [NV] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd0, 2'd1, 2'd2, 2'd3};
  localparam logic [127:0] T_A [NV] = '{
    128'h0, 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF,
    128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 128'hDEAD_BEEF_CAFE_F00D_1234_5678_9ABC_DEF0,
    128'hA5A5_5A5A_0F0F_F0F0_3C3C_C3C3_6969_9696, 128'h0,
    128'hFFFF_0000_FFFF_0000_1111_2222_3333_4444, 128'h8000_0000_0000_0001_0000_0000_0000_0000};
  localparam logic [127:0] T_B [NV] = '{
    128'h0706_0504_0302_0100_FFFE_FDFC_FBFA_F9F8, 128'h000F_000E_0007_0000_FFF1_0123_0008_ABCD,
    128'h0000_001F_0000_0000_FFFF_FFE1_0000_0010, 128'h0000_0000_0000_003F_FFFF_FFFF_FFFF_FFC0,
    128'h1122_3344_5566_7788_99AA_BBCC_DDEE_FF00, 128'h1234_5678_9ABC_DEF0_0F1E_2D3C_4B5A_6978,
    128'h0000_0000_FFFF_FFFF_1234_5678_0000_0007, 128'hFFFF_FFFF_FFFF_FFBF_0000_0000_0000_0000};

  function automatic logic [31:0] mk(logic [5:0] maj, logic [2:0] op, logic [1:0] df,
                                     logic [4:0] wd, logic [5:0] mnr);
    return {maj, op, df, 5'd3, 5'd2, wd, mnr};
  endfunction

  function automatic logic [127:0] model(logic [1:0] fmt, logic [127:0] a, logic [127:0] b);
    int w = 8 << fmt;
    logic [127:0] r = a;
    for (int j = 0; j < 128; j++) begin
      int lane = j / w;
      int idx = int'((b >> (lane * w)) & 128'(w - 1));
      if (idx == j % w) r[j] = ~a[j];
    end
    return r;
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(logic [31:0] w, logic en, logic [127:0] a, logic [127:0] b);
    @(negedge clk);
    issue = 1'b1; insn = w; vec_en = en; src_a = a; src_b = b;
    @(negedge clk);
    issue = 1'b0; insn = '0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [127:0] r1;
    repeat (3) @(negedge clk);
    check("R11 reset", {res_q, 3'(dst_q), res_vld, exc_rsvd, exc_off}, '0);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      run(mk(6'b011110, 3'b101, T_FMT[k], 5'(k + 1), 6'b001101), 1'b1, T_A[k], T_B[k]);
      case (T_FMT[k])
        2'd0: check("R2 byte lanes", res_q, model(2'd0, T_A[k], T_B[k]));
        2'd1: check("R3 half lanes", res_q, model(2'd1, T_A[k], T_B[k]));
        2'd2: check("R4 word lanes", res_q, model(2'd2, T_A[k], T_B[k]));
        default: check("R5 dword lanes", res_q, model(2'd3, T_A[k], T_B[k]));
      endcase
      check("R1 valid", 128'(res_vld), 128'd1);
      check("R7 dest", 128'(dst_q), 128'(k + 1));
    end

    // R6: upper index bits set must give the same result as clean indices
    run(mk(6'b011110, 3'b101, 2'd1, 5'd9, 6'b001101), 1'b1, T_A[2], 128'h0003_0005_0007_0009_000B_000D_000F_0001);
    r1 = res_q;
    run(mk(6'b011110, 3'b101, 2'd1, 5'd9, 6'b001101), 1'b1, T_A[2], 128'hFFF3_8005_1237_ABC9_F00B_00ED_7FFF_0101);
    check("R6 upper bits ignored", res_q, r1);

    // R1: strobe is one cycle wide
    @(negedge clk);
    check("R1 single cycle", 128'(res_vld), 128'd0);

    // R8: disabled unit
    run(mk(6'b011110, 3'b101, 2'd0, 5'd4, 6'b001101), 1'b0, T_A[3], T_B[3]);
    check("R8 off flag", {125'd0, res_vld, exc_rsvd, exc_off}, 128'b001);
    run(mk(6'b011110, 3'b000, 2'd0, 5'd4, 6'b000000), 1'b0, T_A[3], T_B[3]);
    check("R8 off beats reserved", {125'd0, res_vld, exc_rsvd, exc_off}, 128'b001);

    // R9: reserved encodings
    run(mk(6'b011110, 3'b100, 2'd2, 5'd4, 6'b001101), 1'b1, T_A[3], T_B[3]);
    check("R9 bad op", {125'd0, res_vld, exc_rsvd, exc_off}, 128'b010);
    run(mk(6'b011110, 3'b101, 2'd2, 5'd4, 6'b001100), 1'b1, T_A[3], T_B[3]);
    check("R9 bad minor", {125'd0, res_vld, exc_rsvd, exc_off}, 128'b010);

    // R10: foreign major opcode, result register unchanged since last valid op
    run(mk(6'b011111, 3'b101, 2'd0, 5'd4, 6'b001101), 1'b1, T_A[4], T_B[4]);
    check("R10 foreign flags", {125'd0, res_vld, exc_rsvd, exc_off}, 128'b000);
    check("R10 result held", res_q, r1);

    // R12 with R11: reset mid-stream clears everything
    run(mk(6'b011110, 3'b101, 2'd3, 5'd31, 6'b001101), 1'b1, T_A[7], T_B[7]);
    check("R12 only valid", {125'd0, res_vld, exc_rsvd, exc_off}, 128'b100);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R11 reset again", {res_q, 3'(dst_q), res_vld, exc_rsvd, exc_off}, '0);

    finish_run();
  end
endmodule